// File: doc/BRIEF.md
# Event Queue Request Dispatcher

This block takes channel events, files each one into one of four event queues and serves every queue in arrival order. When an event reaches the head of its queue, the block looks up that channel's entry in a small internal parameter store and checks it. If the entry is usable, the block offers a transfer request on the transfer port that belongs to that queue. If it is not usable, the block drops it and records an error against the channel.

Each request port uses a plain valid/ready handshake. The block raises sticky error flags in three cases: an event arrives for a channel that is already queued, an event arrives at a full queue, or an event lands in a queue that already holds its threshold number of entries. A pending-interrupt vector gathers completion codes. A code arrives either from the transfer side, or at once when a request marked for early completion is handed over. Each bit is cleared by writing 1 to it, and an enable mask gates the interrupt line.

Top module: `evq_dispatch`

## Requirements
- R1: Within one queue, requests leave in the order in which their events were accepted.
- R2: An event accepted on queue q produces its request only on port q. The request carries that channel's destination, count and code.
- R3: The parameter entry is read when the event reaches the queue head. A write made while the event waits in the queue is used. A write made after the entry has moved into the port's holding register is not used.
- R4: An entry whose count is zero produces no request and sets inval_err_o bit (channel).
- R5: While tr_valid_o[q] is high and tr_ready_i[q] is low, the request on port q holds steady.
- R6: An event for a channel that is still waiting in a queue is dropped and sets miss_err_o bit (channel). Once the earlier event has left the queue, a new event for that channel is accepted.
- R7: An event arriving at a queue that holds QDEPTH entries is dropped and sets miss_err_o bit (channel).
- R8: thr_err_o[q] is set by an accepted event that finds queue q already holding at least qthresh_i[q] entries. It is not set while the queue holds fewer than that.
- R9: A request with early=1 and ie=1 sets int_pend_o bit (code) on its handshake. A request with ie=0 sets nothing.
- R10: tr_report_o[q] equals ie AND NOT early. done_valid_i sets int_pend_o bit done_code_i.
- R11: int_o is the OR of int_pend_o AND int_en_i.
- R12: A 1 in int_clr_i clears that pending bit. A set arriving in the same cycle wins.
- R13: Error flags reset to zero and stay set until err_clr_i. err_int_o is the OR of all error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_valid_i | input | 1 | Event strobe |
| ev_chan_i | input | 5 | Event channel |
| ev_queue_i | input | 2 | Target queue |
| qthresh_i | input | 4x5 | Per-queue threshold |
| pw_en_i | input | 1 | Parameter write strobe |
| pw_chan_i | input | 5 | Parameter write channel |
| pw_src_i | input | 32 | Source address |
| pw_dst_i | input | 32 | Destination address |
| pw_cnt_i | input | 16 | Byte count |
| pw_code_i | input | 6 | Completion code |
| pw_ie_i | input | 1 | Completion interrupt enable |
| pw_early_i | input | 1 | Early completion select |
| tr_valid_o | output | 4 | Request valid per port |
| tr_ready_i | input | 4 | Request ready per port |
| tr_src_o | output | 4x32 | Request source |
| tr_dst_o | output | 4x32 | Request destination |
| tr_cnt_o | output | 4x16 | Request count |
| tr_code_o | output | 4x6 | Request completion code |
| tr_report_o | output | 4 | Controller must report completion |
| done_valid_i | input | 1 | Completion code strobe |
| done_code_i | input | 6 | Returned completion code |
| int_en_i | input | 64 | Interrupt enable mask |
| int_clr_i | input | 64 | Write-1-to-clear pulse |
| int_pend_o | output | 64 | Pending interrupt bits |
| int_o | output | 1 | Completion interrupt |
| err_clr_i | input | 1 | Clear all error flags |
| miss_err_o | output | 32 | Missed-event flags per channel |
| inval_err_o | output | 32 | Invalid-entry flags per channel |
| thr_err_o | output | 4 | Threshold flags per queue |
| err_int_o | output | 1 | Error interrupt |

## Verification
The hardest state to reach from the ports is a full queue. The channel-busy rule blocks any repeat event, so a queue can only fill with distinct channels while its port is stalled. The stimulus stalls port 0 and sends one channel, which moves into the holding register and frees its busy mark. It then sends sixteen more distinct channels to fill the FIFO and one further event to overflow it. The threshold check runs on the same fill, so its boundary at the eighth and ninth entry is covered too. Randomized traffic then covers ordering and routing under random back-pressure, and it only sends events for channels the bench has already seen leave.

// File: rtl/evq_pkg.sv
package evq_pkg;
    parameter int ADDR_W = 32;
    parameter int CNT_W  = 16;
    parameter int CODE_W = 6;
    parameter int THR_W  = 5;
    localparam int NCODE = 1 << CODE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] code;
        logic              ie;
        logic              early;
    } prm_t;
endpackage

// File: rtl/evq_fifo.sv
module evq_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 5,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fst_t;

    fst_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (push) begin
            f_d.mem[f_q.wp] = din;
            f_d.wp = f_q.wp + 1'b1;
        end
        if (pop) f_d.rp = f_q.rp + 1'b1;
        f_d.cnt = f_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign dout  = f_q.mem[f_q.rp];
    assign count = f_q.cnt;
    assign full  = (f_q.cnt == CW'(DEPTH));
    assign empty = (f_q.cnt == '0);
endmodule

// File: rtl/evq_prm_ram.sv
module evq_prm_ram
    import evq_pkg::*;
#(
    parameter int NCH = 32,
    parameter int NRD = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [CHW-1:0]           waddr,
    input  prm_t                     wdata,
    input  logic [NRD-1:0][CHW-1:0]  raddr,
    output prm_t [NRD-1:0]           rdata
);
    prm_t [NCH-1:0] m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (we) m_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r] = m_q[raddr[r]];
    end
endmodule

// File: rtl/evq_dispatch.sv
module evq_dispatch
    import evq_pkg::*;
#(
    parameter int NCH    = 32,
    parameter int NQ     = 4,
    parameter int QDEPTH = 16,
    localparam int CHW   = $clog2(NCH),
    localparam int QW    = $clog2(NQ),
    localparam int CW    = $clog2(QDEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ev_valid_i,
    input  logic [CHW-1:0]               ev_chan_i,
    input  logic [QW-1:0]                ev_queue_i,
    input  logic [NQ-1:0][THR_W-1:0]     qthresh_i,
    input  logic                         pw_en_i,
    input  logic [CHW-1:0]               pw_chan_i,
    input  logic [ADDR_W-1:0]            pw_src_i,
    input  logic [ADDR_W-1:0]            pw_dst_i,
    input  logic [CNT_W-1:0]             pw_cnt_i,
    input  logic [CODE_W-1:0]            pw_code_i,
    input  logic                         pw_ie_i,
    input  logic                         pw_early_i,
    output logic [NQ-1:0]                tr_valid_o,
    input  logic [NQ-1:0]                tr_ready_i,
    output logic [NQ-1:0][ADDR_W-1:0]    tr_src_o,
    output logic [NQ-1:0][ADDR_W-1:0]    tr_dst_o,
    output logic [NQ-1:0][CNT_W-1:0]     tr_cnt_o,
    output logic [NQ-1:0][CODE_W-1:0]    tr_code_o,
    output logic [NQ-1:0]                tr_report_o,
    input  logic                         done_valid_i,
    input  logic [CODE_W-1:0]            done_code_i,
    input  logic [NCODE-1:0]             int_en_i,
    input  logic [NCODE-1:0]             int_clr_i,
    output logic [NCODE-1:0]             int_pend_o,
    output logic                         int_o,
    input  logic                         err_clr_i,
    output logic [NCH-1:0]               miss_err_o,
    output logic [NCH-1:0]               inval_err_o,
    output logic [NQ-1:0]                thr_err_o,
    output logic                         err_int_o
);
    typedef struct packed {
        logic [NQ-1:0]    hv;
        prm_t [NQ-1:0]    hp;
        logic [NCH-1:0]   busy;
        logic [NCH-1:0]   miss;
        logic [NCH-1:0]   inval;
        logic [NQ-1:0]    thr;
        logic [NCODE-1:0] pend;
    } st_t;

    st_t s_d, s_q;

    logic [NQ-1:0]           push, pop, f_full, f_empty;
    logic [NQ-1:0][CHW-1:0]  f_dout;
    logic [NQ-1:0][CW-1:0]   f_cnt;
    prm_t [NQ-1:0]           rd_prm;
    prm_t                    wr_prm;

    assign wr_prm = '{src: pw_src_i, dst: pw_dst_i, cnt: pw_cnt_i,
                      code: pw_code_i, ie: pw_ie_i, early: pw_early_i};

    for (genvar q = 0; q < NQ; q++) begin : g_q
        evq_fifo #(.DEPTH(QDEPTH), .W(CHW)) fifo_i (
            .clk(clk), .rst_n(rst_n),
            .push(push[q]), .din(ev_chan_i),
            .pop(pop[q]), .dout(f_dout[q]),
            .count(f_cnt[q]), .full(f_full[q]), .empty(f_empty[q])
        );
    end

    evq_prm_ram #(.NCH(NCH), .NRD(NQ)) ram_i (
        .clk(clk), .rst_n(rst_n),
        .we(pw_en_i), .waddr(pw_chan_i), .wdata(wr_prm),
        .raddr(f_dout), .rdata(rd_prm)
    );

    always_comb begin
        s_d  = s_q;
        push = '0;
        pop  = '0;
        s_d.pend = s_q.pend & ~int_clr_i;
        if (err_clr_i) begin
            s_d.miss  = '0;
            s_d.inval = '0;
            s_d.thr   = '0;
        end
        for (int q = 0; q < NQ; q++) begin
            if (s_q.hv[q] && tr_ready_i[q]) begin
                s_d.hv[q] = 1'b0;
                if (s_q.hp[q].early && s_q.hp[q].ie)
                    s_d.pend[s_q.hp[q].code] = 1'b1;
            end
            pop[q] = !f_empty[q] && !s_q.hv[q];
            if (pop[q]) begin
                s_d.busy[f_dout[q]] = 1'b0;
                if (rd_prm[q].cnt == '0) begin
                    s_d.inval[f_dout[q]] = 1'b1;
                end else begin
                    s_d.hv[q] = 1'b1;
                    s_d.hp[q] = rd_prm[q];
                end
            end
        end
        if (ev_valid_i) begin
            if (s_q.busy[ev_chan_i] || f_full[ev_queue_i]) begin
                s_d.miss[ev_chan_i] = 1'b1;
            end else begin
                push[ev_queue_i]    = 1'b1;
                s_d.busy[ev_chan_i] = 1'b1;
                if (32'(f_cnt[ev_queue_i]) >= 32'(qthresh_i[ev_queue_i]))
                    s_d.thr[ev_queue_i] = 1'b1;
            end
        end
        if (done_valid_i) s_d.pend[done_code_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_out
        assign tr_src_o[q]    = s_q.hp[q].src;
        assign tr_dst_o[q]    = s_q.hp[q].dst;
        assign tr_cnt_o[q]    = s_q.hp[q].cnt;
        assign tr_code_o[q]   = s_q.hp[q].code;
        assign tr_report_o[q] = s_q.hp[q].ie & ~s_q.hp[q].early;
    end

    assign tr_valid_o  = s_q.hv;
    assign int_pend_o  = s_q.pend;
    assign int_o       = |(s_q.pend & int_en_i);
    assign miss_err_o  = s_q.miss;
    assign inval_err_o = s_q.inval;
    assign thr_err_o   = s_q.thr;
    assign err_int_o   = |{s_q.miss, s_q.inval, s_q.thr};
endmodule

// File: rtl/evq_dispatch_chk.sv
module evq_dispatch_chk
    import evq_pkg::*;
#(
    parameter int NQ = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NQ-1:0]             tr_valid_o,
    input logic [NQ-1:0]             tr_ready_i,
    input logic [NQ-1:0][ADDR_W-1:0] tr_src_o,
    input logic [NQ-1:0][CNT_W-1:0]  tr_cnt_o,
    input logic [NQ-1:0][CODE_W-1:0] tr_code_o,
    input logic                      done_valid_i,
    input logic [NCODE-1:0]          int_en_i,
    input logic [NCODE-1:0]          int_clr_i,
    input logic [NCODE-1:0]          int_pend_o,
    input logic                      int_o,
    input logic                      err_clr_i,
    input logic                      err_int_o
);
    for (genvar q = 0; q < NQ; q++) begin : g_a
        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            tr_valid_o[q] && !tr_ready_i[q] |=> tr_valid_o[q] && $stable(tr_src_o[q])
                && $stable(tr_cnt_o[q]) && $stable(tr_code_o[q]));
        p_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            tr_valid_o[q] |-> tr_cnt_o[q] != '0);
    end

    p_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        int_en_i == '0 |-> !int_o);

    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (&int_clr_i) && !done_valid_i && !(|(tr_valid_o & tr_ready_i)) |=> int_pend_o == '0);

    p_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        err_int_o && !err_clr_i |=> err_int_o);
endmodule

bind evq_dispatch evq_dispatch_chk #(.NQ(NQ)) chk_i (.*);

// File: tb/evq_dispatch_tb_top.sv
`timescale 1ns/1ps
module evq_dispatch_tb_top;
    import evq_pkg::*;
    localparam int NCH = 32, NQ = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic ev_valid_i = 0; logic [4:0] ev_chan_i = 0; logic [1:0] ev_queue_i = 0;
    logic [NQ-1:0][THR_W-1:0] qthresh_i;
    logic pw_en_i = 0; logic [4:0] pw_chan_i = 0;
    logic [31:0] pw_src_i = 0, pw_dst_i = 0; logic [15:0] pw_cnt_i = 0;
    logic [5:0] pw_code_i = 0; logic pw_ie_i = 0, pw_early_i = 0;
    logic [NQ-1:0] tr_valid_o, tr_ready_i = '0, tr_report_o;
    logic [NQ-1:0][31:0] tr_src_o, tr_dst_o;
    logic [NQ-1:0][15:0] tr_cnt_o;
    logic [NQ-1:0][5:0]  tr_code_o;
    logic done_valid_i = 0; logic [5:0] done_code_i = 0;
    logic [63:0] int_en_i = '0, int_clr_i = '0, int_pend_o;
    logic int_o, err_clr_i = 0, err_int_o;
    logic [NCH-1:0] miss_err_o, inval_err_o;
    logic [NQ-1:0] thr_err_o;

    evq_dispatch dut_i (.*);

    int vectors = 0, fails = 0;
    int got[NQ][$];
    int got_src[NQ][$];
    int expq[NQ][$];
    logic [31:0] b_dst[NCH]; logic [15:0] b_cnt[NCH]; logic [5:0] b_code[NCH];
    logic b_ie[NCH], b_early[NCH], outst[NCH];
    logic [63:0] exp_pend = '0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(posedge clk); #1; endtask
    task automatic wait_n(int n); for (int i = 0; i < n; i++) tick(); endtask

    task automatic send_ev(int ch, int q);
        ev_valid_i = 1; ev_chan_i = 5'(ch); ev_queue_i = 2'(q);
        tick(); ev_valid_i = 0;
    endtask

    task automatic wparam(int ch, logic [31:0] src);
        pw_en_i = 1; pw_chan_i = 5'(ch); pw_src_i = src; pw_dst_i = b_dst[ch];
        pw_cnt_i = b_cnt[ch]; pw_code_i = b_code[ch]; pw_ie_i = b_ie[ch]; pw_early_i = b_early[ch];
        tick(); pw_en_i = 0;
    endtask

    task automatic clear_got();
        for (int q = 0; q < NQ; q++) begin got[q].delete(); got_src[q].delete(); end
    endtask

    // Monitor: handshakes at the falling edge, field checks for R2, R9 and R10
    always @(negedge clk) begin
        if (rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                if (tr_valid_o[q] && tr_ready_i[q]) begin
                    int ch;
                    ch = int'(tr_src_o[q] >> 8);
                    got[q].push_back(ch);
                    got_src[q].push_back(int'(tr_src_o[q]));
                    chk("R2 dst", tr_dst_o[q], b_dst[ch]);
                    chk("R2 cnt", tr_cnt_o[q], b_cnt[ch]);
                    chk("R2 code", tr_code_o[q], b_code[ch]);
                    chk("R10 report", tr_report_o[q], b_ie[ch] & ~b_early[ch]);
                    if (b_early[ch] && b_ie[ch]) exp_pend[b_code[ch]] = 1'b1;
                    outst[ch] = 1'b0;
                end
            end
        end
    end

    bit finished = 0;
    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int q = 0; q < NQ; q++) qthresh_i[q] = 5'd31;
        for (int c = 0; c < NCH; c++) begin
            b_dst[c] = 32'h8000_0000 | c; b_cnt[c] = (c == 5) ? 16'd0 : 16'(c + 1);
            b_code[c] = 6'(c + 8); b_ie[c] = (c != 7); b_early[c] = c[0]; outst[c] = 0;
        end
        wait_n(4); rst_n = 1; tick();
        chk("R13 reset valid", tr_valid_o, 0);
        chk("R13 reset pend", int_pend_o, 0);
        chk("R13 reset err", err_int_o, 0);
        chk("R11 reset int", int_o, 0);
        for (int c = 0; c < NCH; c++) wparam(c, 32'(c) << 8);

        // R1: order within one stalled queue
        send_ev(2, 1); send_ev(7, 1); send_ev(9, 1); send_ev(3, 1);
        wait_n(3); tr_ready_i[1] = 1; wait_n(10); tr_ready_i[1] = 0;
        chk("R1 count", got[1].size(), 4);
        if (got[1].size() == 4) begin
            chk("R1 first", got[1][0], 2); chk("R1 second", got[1][1], 7);
            chk("R1 third", got[1][2], 9); chk("R1 fourth", got[1][3], 3);
        end
        chk("R2 other ports idle", got[0].size() + got[2].size() + got[3].size(), 0);
        clear_got();

        // R3: parameter read at the head of the queue
        send_ev(4, 0); send_ev(10, 0); wait_n(3);
        wparam(4, (32'd4 << 8) | 32'h33);
        wparam(10, (32'd10 << 8) | 32'h5A);
        tr_ready_i[0] = 1; wait_n(6); tr_ready_i[0] = 0;
        chk("R3 count", got_src[0].size(), 2);
        if (got_src[0].size() == 2) begin
            chk("R3 held entry unchanged", got_src[0][0], 32'd4 << 8);
            chk("R3 queued entry updated", got_src[0][1], (32'd10 << 8) | 32'h5A);
        end
        clear_got();

        // R4: zero count entry dropped
        tr_ready_i[2] = 1; send_ev(5, 2); wait_n(4); tr_ready_i[2] = 0;
        chk("R4 inval flag", inval_err_o, 32'h20);
        chk("R4 no request", got[2].size(), 0);
        chk("R13 err_int", err_int_o, 1);
        err_clr_i = 1; tick(); err_clr_i = 0;
        chk("R13 cleared", {miss_err_o, inval_err_o, thr_err_o}, 0);
        chk("R13 err_int low", err_int_o, 0);

        // R6: duplicate pending channel
        send_ev(1, 3); wait_n(2);
        send_ev(6, 3); send_ev(6, 3); send_ev(1, 3);
        chk("R6 miss flag", miss_err_o, 32'h40);
        tr_ready_i[3] = 1; wait_n(10); tr_ready_i[3] = 0;
        chk("R6 count", got[3].size(), 3);
        if (got[3].size() == 3) begin
            chk("R6 order a", got[3][0], 1); chk("R6 order b", got[3][1], 6);
            chk("R6 order c", got[3][2], 1);
        end
        clear_got(); err_clr_i = 1; tick(); err_clr_i = 0;

        // R7 and R8: fill queue 0 past its threshold and its depth
        qthresh_i[0] = 5'd8;
        send_ev(0, 0); wait_n(2);
        for (int c = 6; c < 14; c++) send_ev(c, 0);
        chk("R8 below threshold", thr_err_o, 0);
        send_ev(14, 0);
        chk("R8 threshold hit", thr_err_o, 1);
        for (int c = 15; c < 22; c++) send_ev(c, 0);
        chk("R7 no miss while filling", miss_err_o, 0);
        send_ev(22, 0);
        chk("R7 full miss", miss_err_o, 32'h0040_0000);
        tr_ready_i[0] = 1; wait_n(40); tr_ready_i[0] = 0;
        chk("R7 drained count", got[0].size(), 17);
        if (got[0].size() == 17) begin
            chk("R7 first", got[0][0], 0); chk("R7 last", got[0][16], 21);
        end
        clear_got(); err_clr_i = 1; tick(); err_clr_i = 0; qthresh_i[0] = 5'd31;

        // R9..R12: interrupt status
        chk("R9 early pending", int_pend_o, exp_pend);
        chk("R11 masked", int_o, 0);
        int_en_i = '1; tick();
        chk("R11 enabled", int_o, (exp_pend != 0));
        int_clr_i = '1; tick(); int_clr_i = '0; exp_pend = '0;
        chk("R12 cleared", int_pend_o, 0);
        int_en_i = '0;
        done_valid_i = 1; done_code_i = 6'd33; tick(); done_valid_i = 0;
        chk("R10 done sets bit", int_pend_o, 64'h1 << 33);
        int_en_i = 64'h1 << 34; tick();
        chk("R11 other bit enabled", int_o, 0);
        int_en_i = 64'h1 << 33; tick();
        chk("R11 matching bit enabled", int_o, 1);
        done_valid_i = 1; done_code_i = 6'd40; int_clr_i = (64'h1 << 40) | (64'h1 << 33);
        tick(); done_valid_i = 0; int_clr_i = '0;
        chk("R12 set wins", int_pend_o, 64'h1 << 40);
        int_clr_i = '1; tick(); int_clr_i = '0; int_en_i = '0;

        // R1 and R2 under random traffic and back-pressure
        for (int i = 0; i < 800; i++) begin
            for (int q = 0; q < NQ; q++) tr_ready_i[q] = ($urandom % 3) != 0;
            if ($urandom % 2 == 0) begin
                int ch, q;
                ch = int'($urandom % NCH); q = int'($urandom % NQ);
                if (ch != 5 && !outst[ch]) begin
                    outst[ch] = 1; expq[q].push_back(ch); send_ev(ch, q);
                end else tick();
            end else tick();
        end
        tr_ready_i = '1; wait_n(40); tr_ready_i = '0;
        for (int q = 0; q < NQ; q++) begin
            chk("R2 random count", got[q].size(), expq[q].size());
            if (got[q].size() == expq[q].size())
                for (int k = 0; k < got[q].size(); k++) chk("R1 random order", got[q][k], expq[q][k]);
        end
        chk("R6 no random miss", miss_err_o, 0);
        chk("R8 no random threshold", thr_err_o, 0);
        chk("R9 random pending", int_pend_o, exp_pend);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule